// File: doc/BRIEF.md
# XOR-Checked Compute Result Corrector

This block sits between a requester and a memory array that can evaluate a bitwise or arithmetic function of two stored rows in a single compute access. Every row is stored as an extended Hamming codeword (single error correct, double error detect). During every compute access the array also returns the bitwise XOR of the two selected codewords. Because the code is linear, that XOR is itself a codeword of the XOR of the two data words. The block therefore runs the syndrome check on this XOR output whatever operation was asked for.

When the requested operation is XOR, a single-bit error is repaired by inverting the indicated bit, with no further array traffic. A double-bit error is reported as uncorrectable. For any other operation, an error seen on the XOR output means the requested result cannot be trusted. The block then issues two ordinary reads, one for each operand row, corrects each word, and recomputes the operation itself, for three array accesses in total. While a request is in flight, busy is high and new requests are ignored.

The controller has six states. IDLE accepts a request and moves to CHECK, which issues the compute access. On the array response, CHECK goes to DONE if the XOR output is clean or the operation is XOR, and to REREAD_A otherwise. REREAD_A issues the read of row A and moves to REREAD_B when the data returns. REREAD_B does the same for row B and moves to RECOMPUTE. RECOMPUTE evaluates the operation on the corrected operands and moves to DONE. DONE presents the response for one cycle and returns to IDLE.

Top module: `cim_xor_guard`

## Requirements
- R1: After reset, busy, rsp_valid and arr_req are all low.
- R2: A request is accepted when req_valid is high while busy is low. Busy is high from the cycle after acceptance up to and including the response cycle. A req_valid pulse while busy is high starts no access and yields no response.
- R3: A codeword has 13 bits. Bit 0 is the even overall parity of bits 1 to 12. Bits 1, 2, 4 and 8 are Hamming checks, each the even parity of the positions that have the matching index bit set. Data bits 0 to 7 sit, in order, at positions 3, 5, 6, 7, 9, 10, 11 and 12. A read returns a stored codeword on arr_rsp_cw. A compute access returns the XOR of the two stored codewords on arr_rsp_cw, and the requested function of the data on arr_rsp_op.
- R4: If the XOR output of a compute access is error-free, the response carries arr_rsp_op with rsp_dvalid high and rsp_err low, after exactly one array access.
- R5: For an XOR request whose XOR output holds a single-bit error (a data, check or overall bit), the response carries the corrected XOR data after exactly one array access.
- R6: For an XOR request whose XOR output holds a double-bit error, the response has rsp_err high, rsp_dvalid low and rsp_data zero, after exactly one array access.
- R7: For a non-XOR request with a single- or double-bit error on the XOR output, the block issues two reads with arr_cim low, first row A and then row B, each on arr_addr_a. It corrects both words and returns the recomputed result, for three array accesses in total.
- R8: If either reread word is uncorrectable, the response has rsp_err high, rsp_dvalid low and rsp_data zero.
- R9: Operation codes are AND=0, OR=1, XOR=2 and ADD=3, where ADD is the 8-bit sum modulo 256.
- R10: arr_req is a single-cycle pulse per access. The block waits any number of cycles for arr_rsp_valid.
- R11: rsp_valid is a single-cycle pulse, and busy is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Requested operation code |
| req_addr_a | input | 4 | Row of operand A |
| req_addr_b | input | 4 | Row of operand B |
| busy | output | 1 | Request in flight |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 8 | Result data, zero when invalid |
| rsp_dvalid | output | 1 | Result data is trustworthy |
| rsp_err | output | 1 | Uncorrectable error seen |
| arr_req | output | 1 | Array access strobe |
| arr_cim | output | 1 | 1 for a compute access, 0 for a plain read |
| arr_op | output | 2 | Operation for a compute access |
| arr_addr_a | output | 4 | First row, and the row of a plain read |
| arr_addr_b | output | 4 | Second row of a compute access |
| arr_rsp_valid | input | 1 | Array response strobe |
| arr_rsp_cw | input | 13 | XOR codeword, or the read codeword |
| arr_rsp_op | input | 8 | Requested-function data of a compute access |

## Verification
The block is exercised with clean rows for all four operations. This shows that the fast path forwards the array result after one access. XOR requests are then given injected single flips on a data bit and on the overall parity bit, and a double flip. These separate in-place repair from error reporting, and each should cost no extra access. Non-XOR requests are given sense-path errors and stored-row errors, where the array's own result is wrong. These show that the block uses the recomputed value and the A-then-B read order. A double-error stored row shows that an uncorrectable reread is flagged. A request strobed while busy shows that it is dropped.

// File: rtl/cimx_pkg.sv
package cimx_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'd0,
        OP_OR  = 2'd1,
        OP_XOR = 2'd2,
        OP_ADD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_BAD   = 2'd2
    } ecc_st_e;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_CHECK     = 3'd1,
        S_REREAD_A  = 3'd2,
        S_REREAD_B  = 3'd3,
        S_RECOMPUTE = 3'd4,
        S_DONE      = 3'd5
    } state_e;

    // number of Hamming check bits for dw data bits (overall parity excluded)
    function automatic int chk_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // codeword position of data bit k: k-th index >= 3 that is not a power of two
    function automatic int data_pos(input int k);
        int cnt;
        cnt = 0;
        for (int p = 3; p < 4096; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == k) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/cimx_secded_dec.sv
module cimx_secded_dec #(
    parameter int DW = 8,
    localparam int PW = cimx_pkg::chk_bits(DW),
    localparam int CW = DW + PW + 1
) (
    input  logic [CW-1:0]       cw_i,
    output logic [DW-1:0]       data_o,
    output cimx_pkg::ecc_st_e   st_o
);
    logic [PW-1:0] syn;
    logic          par;
    logic [CW-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int i = 1; i < CW; i++) begin
            if (cw_i[i]) syn = syn ^ i[PW-1:0];
        end
        par = ^cw_i;
        fixed = cw_i;
        for (int i = 0; i < CW; i++) begin
            if (par && syn == i[PW-1:0]) fixed[i] = ~cw_i[i];
        end
        if (!par && syn == '0)
            st_o = cimx_pkg::ECC_CLEAN;
        else if (par && int'(syn) < CW)
            st_o = cimx_pkg::ECC_FIXED;
        else
            st_o = cimx_pkg::ECC_BAD;
    end

    for (genvar k = 0; k < DW; k++) begin : g_extract
        localparam int POS = cimx_pkg::data_pos(k);
        assign data_o[k] = fixed[POS];
    end

endmodule

// File: rtl/cimx_op_unit.sv
module cimx_op_unit #(
    parameter int DW = 8
) (
    input  cimx_pkg::op_e  op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output logic [DW-1:0]  res_o
);
    always_comb begin
        unique case (op_i)
            cimx_pkg::OP_AND: res_o = a_i & b_i;
            cimx_pkg::OP_OR:  res_o = a_i | b_i;
            cimx_pkg::OP_XOR: res_o = a_i ^ b_i;
            cimx_pkg::OP_ADD: res_o = a_i + b_i;
            default:          res_o = '0;
        endcase
    end
endmodule

// File: rtl/cim_xor_guard.sv
module cim_xor_guard #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int PW = cimx_pkg::chk_bits(DW),
    localparam int CW = DW + PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr_a,
    input  logic [AW-1:0] req_addr_b,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_dvalid,
    output logic          rsp_err,
    output logic          arr_req,
    output logic          arr_cim,
    output logic [1:0]    arr_op,
    output logic [AW-1:0] arr_addr_a,
    output logic [AW-1:0] arr_addr_b,
    input  logic          arr_rsp_valid,
    input  logic [CW-1:0] arr_rsp_cw,
    input  logic [DW-1:0] arr_rsp_op
);
    import cimx_pkg::*;

    state_e        state_q, state_d;
    op_e           op_q;
    logic [AW-1:0] addr_a_q, addr_b_q;
    logic          issue_q;
    logic [DW-1:0] opa_q, opb_q, res_q;
    logic          err_q;

    logic [DW-1:0] dec_data;
    ecc_st_e       dec_st;
    logic [DW-1:0] alu_res;

    cimx_secded_dec #(.DW(DW)) u_dec (
        .cw_i   (arr_rsp_cw),
        .data_o (dec_data),
        .st_o   (dec_st)
    );

    cimx_op_unit #(.DW(DW)) u_alu (
        .op_i  (op_q),
        .a_i   (opa_q),
        .b_i   (opb_q),
        .res_o (alu_res)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid) state_d = S_CHECK;
            S_CHECK:     if (arr_rsp_valid)
                             state_d = (dec_st == ECC_CLEAN || op_q == OP_XOR) ? S_DONE : S_REREAD_A;
            S_REREAD_A:  if (arr_rsp_valid) state_d = S_REREAD_B;
            S_REREAD_B:  if (arr_rsp_valid) state_d = S_RECOMPUTE;
            S_RECOMPUTE: state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            issue_q <= 1'b0;
        end else begin
            state_q <= state_d;
            issue_q <= (state_d != state_q) &&
                       (state_d == S_CHECK || state_d == S_REREAD_A || state_d == S_REREAD_B);
        end
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_AND;
            addr_a_q <= '0;
            addr_b_q <= '0;
            opa_q    <= '0;
            opb_q    <= '0;
            res_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q     <= op_e'(req_op);
                    addr_a_q <= req_addr_a;
                    addr_b_q <= req_addr_b;
                    err_q    <= 1'b0;
                end
                S_CHECK: if (arr_rsp_valid) begin
                    if (dec_st == ECC_CLEAN) begin
                        res_q <= arr_rsp_op;
                    end else if (op_q == OP_XOR) begin
                        res_q <= dec_data;
                        err_q <= (dec_st == ECC_BAD);
                    end
                end
                S_REREAD_A: if (arr_rsp_valid) begin
                    opa_q <= dec_data;
                    if (dec_st == ECC_BAD) err_q <= 1'b1;
                end
                S_REREAD_B: if (arr_rsp_valid) begin
                    opb_q <= dec_data;
                    if (dec_st == ECC_BAD) err_q <= 1'b1;
                end
                S_RECOMPUTE: res_q <= alu_res;
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        arr_req    = issue_q;
        arr_cim    = (state_q == S_CHECK);
        arr_op     = op_q;
        arr_addr_a = (state_q == S_REREAD_B) ? addr_b_q : addr_a_q;
        arr_addr_b = addr_b_q;
        rsp_valid  = (state_q == S_DONE);
        rsp_err    = (state_q == S_DONE) && err_q;
        rsp_dvalid = (state_q == S_DONE) && !err_q;
        rsp_data   = ((state_q == S_DONE) && !err_q) ? res_q : '0;
    end

    // accepted request issues a compute access next cycle
    assert_accept_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && arr_req && arr_cim));

    // XOR requests never fall back to rereads
    assert_xor_no_reread_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && op_q == OP_XOR && arr_rsp_valid) |=> (state_q == S_DONE));

    // fallback accesses are plain reads
    assert_reread_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && (state_q == S_REREAD_A || state_q == S_REREAD_B)) |-> !arr_cim);

    // access strobe lasts one cycle
    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> !arr_req);

    // response strobe lasts one cycle, then idle
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // uncorrectable word from a reread ends in an error response
    assert_reread_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RECOMPUTE && err_q) |=> (rsp_err && !rsp_dvalid));

endmodule

// File: tb/cim_xor_guard_bench.sv
`timescale 1ns/1ps
module cim_xor_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [3:0]  req_addr_a = 4'd0, req_addr_b = 4'd0;
    logic        busy, rsp_valid, rsp_dvalid, rsp_err;
    logic [7:0]  rsp_data;
    logic        arr_req, arr_cim;
    logic [1:0]  arr_op;
    logic [3:0]  arr_addr_a, arr_addr_b;
    logic        arr_rsp_valid = 1'b0;
    logic [12:0] arr_rsp_cw = '0;
    logic [7:0]  arr_rsp_op = '0;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    cim_xor_guard u_cim_xor_guard (
        .clk, .rst_n, .req_valid, .req_op, .req_addr_a, .req_addr_b,
        .busy, .rsp_valid, .rsp_data, .rsp_dvalid, .rsp_err,
        .arr_req, .arr_cim, .arr_op, .arr_addr_a, .arr_addr_b,
        .arr_rsp_valid, .arr_rsp_cw, .arr_rsp_op
    );

    // ---------------- behavioural reference helpers
    function automatic logic [12:0] enc(input logic [7:0] d);
        logic [12:0] c;
        int k;
        c = '0; k = 0;
        for (int p = 1; p < 13; p++)
            if ((p & (p - 1)) != 0) begin c[p] = d[k]; k++; end
        for (int r = 0; r < 4; r++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < 13; p++)
                if (((p >> r) & 1) == 1 && p != (1 << r)) x = x ^ c[p];
            c[1 << r] = x;
        end
        c[0] = ^c[12:1];
        return c;
    endfunction

    function automatic logic [7:0] raw(input logic [12:0] c);
        logic [7:0] d;
        int k;
        k = 0; d = '0;
        for (int p = 1; p < 13; p++)
            if ((p & (p - 1)) != 0) begin d[k] = c[p]; k++; end
        return d;
    endfunction

    function automatic logic [7:0] ref_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            2'd0: return a & b;
            2'd1: return a | b;
            2'd2: return a ^ b;
            default: return 8'((int'(a) + int'(b)) % 256);
        endcase
    endfunction

    // ---------------- array model
    logic [12:0] mem [0:15];
    logic [12:0] xinj = '0;
    int          lat = 1;
    int          cnt = 0;
    logic [12:0] pend_cw;
    logic [7:0]  pend_op;
    int          acc_cnt = 0;
    int          rsp_pulses = 0;
    logic        acc_cim [0:7];
    logic [3:0]  acc_addr [0:7];

    always @(negedge clk) begin
        arr_rsp_valid = 1'b0;
        if (rsp_valid) rsp_pulses++;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                arr_rsp_valid = 1'b1;
                arr_rsp_cw = pend_cw;
                arr_rsp_op = pend_op;
            end
        end
        if (arr_req) begin
            if (acc_cnt < 8) begin
                acc_cim[acc_cnt] = arr_cim;
                acc_addr[acc_cnt] = arr_addr_a;
            end
            acc_cnt++;
            if (arr_cim) begin
                pend_cw = mem[arr_addr_a] ^ mem[arr_addr_b] ^ xinj;
                pend_op = ref_op(arr_op, raw(mem[arr_addr_a]), raw(mem[arr_addr_b]));
            end else begin
                pend_cw = mem[arr_addr_a];
                pend_op = '0;
            end
            cnt = lat;
        end
    end

    // ---------------- checks
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b,
                       input logic [12:0] inj, input int l,
                       input bit exp_err, input logic [7:0] exp_data, input int exp_acc,
                       input bit poke, input string req);
        int n;
        xinj = inj; lat = l; acc_cnt = 0; rsp_pulses = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr_a = a; req_addr_b = b;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R2 busy after accept", int'(busy), 1);
        n = 0;
        while (rsp_valid !== 1'b1 && n < 60) begin
            if (poke && n == 1) begin
                req_valid = 1'b1; req_op = 2'd1; req_addr_a = 4'd3; req_addr_b = 4'd4;
            end else req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(n < 60, {req, " response arrives (watchdog)"}, n, 0);
        chk(rsp_err === exp_err, {req, " rsp_err"}, int'(rsp_err), int'(exp_err));
        chk(rsp_dvalid === !exp_err, {req, " rsp_dvalid"}, int'(rsp_dvalid), int'(!exp_err));
        chk(rsp_data === (exp_err ? 8'h00 : exp_data), {req, " rsp_data"}, int'(rsp_data),
            int'(exp_err ? 8'h00 : exp_data));
        @(negedge clk);
        chk(busy === 1'b0 && rsp_valid === 1'b0, "R11 idle after response", int'({busy, rsp_valid}), 0);
        repeat (4) @(negedge clk);
        chk(acc_cnt == exp_acc, {req, " access count"}, acc_cnt, exp_acc);
        chk(rsp_pulses == 1, "R11 single response pulse", rsp_pulses, 1);
        if (exp_acc == 3) begin
            chk(acc_cim[0] === 1'b1 && acc_cim[1] === 1'b0 && acc_cim[2] === 1'b0,
                "R7 access kinds compute,read,read", int'({acc_cim[0], acc_cim[1], acc_cim[2]}), 4);
            chk(acc_addr[1] === a && acc_addr[2] === b, "R7 reread order A then B",
                int'({acc_addr[1], acc_addr[2]}), int'({a, b}));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        mem[0] = enc(8'h00);
        mem[1] = enc(8'h5A);
        mem[2] = enc(8'h3C);
        mem[3] = enc(8'hFF);
        mem[4] = enc(8'h81);
        mem[5] = enc(8'h10) ^ 13'h0080;      // stored single error at bit 7
        mem[6] = enc(8'h77) ^ 13'h0028;      // stored double error at bits 3 and 5
        for (int i = 7; i < 16; i++) mem[i] = enc(8'(i));

        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && rsp_valid === 1'b0 && arr_req === 1'b0, "R1 reset state",
            int'({busy, rsp_valid, arr_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && arr_req === 1'b0, "R1 idle after reset", int'({busy, arr_req}), 0);

        // R4 / R9 clean fast path, each opcode
        run(2'd0, 4'd1, 4'd2, 13'h0, 1, 1'b0, ref_op(2'd0, 8'h5A, 8'h3C), 1, 1'b0, "R4 R9 AND clean");
        run(2'd1, 4'd1, 4'd2, 13'h0, 2, 1'b0, ref_op(2'd1, 8'h5A, 8'h3C), 1, 1'b0, "R4 R9 OR clean");
        run(2'd3, 4'd3, 4'd4, 13'h0, 3, 1'b0, 8'h80, 1, 1'b0, "R4 R9 ADD wraps mod 256");
        run(2'd2, 4'd1, 4'd2, 13'h0, 1, 1'b0, 8'h66, 1, 1'b0, "R4 R9 XOR clean");
        // R5 single flips on XOR path
        run(2'd2, 4'd1, 4'd2, 13'h0040, 1, 1'b0, 8'h66, 1, 1'b0, "R5 XOR data-bit flip");
        run(2'd2, 4'd1, 4'd2, 13'h0001, 2, 1'b0, 8'h66, 1, 1'b0, "R5 XOR overall-bit flip");
        run(2'd2, 4'd5, 4'd2, 13'h0, 1, 1'b0, 8'h2C, 1, 1'b0, "R5 R3 XOR stored-row flip");
        // R6 double on XOR
        run(2'd2, 4'd1, 4'd2, 13'h0208, 1, 1'b1, 8'h00, 1, 1'b0, "R6 XOR double flip");
        run(2'd2, 4'd6, 4'd2, 13'h0, 2, 1'b1, 8'h00, 1, 1'b0, "R6 XOR stored double");
        // R7 fallback on non-XOR
        run(2'd0, 4'd1, 4'd2, 13'h0020, 1, 1'b0, 8'h18, 3, 1'b0, "R7 AND sense single");
        run(2'd3, 4'd5, 4'd2, 13'h0, 2, 1'b0, 8'h4C, 3, 1'b0, "R7 R3 ADD stored-row single");
        run(2'd1, 4'd1, 4'd2, 13'h0104, 3, 1'b0, 8'h7E, 3, 1'b0, "R7 OR sense double");
        // R8 uncorrectable reread
        run(2'd0, 4'd6, 4'd2, 13'h0, 1, 1'b1, 8'h00, 3, 1'b0, "R8 AND reread double");
        // R2 request while busy ignored; R10 slow array
        run(2'd0, 4'd1, 4'd2, 13'h0, 5, 1'b0, 8'h18, 1, 1'b1, "R2 R10 poke while busy");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule